// File: doc/BRIEF.md
# Re-reading Bounded Buffer

This block joins a producer and a consumer through a ring of N storage cells. The control state is held only in single-bit flags. Each side's position is a one-hot flag set, and that set is changed only by the side that owns it. The other side may read it but never changes it. The producer stores each item into the cell it owns. It then moves to the following cell, but only if the consumer is not sitting there. If the consumer is there, the producer holds its position, drops its ready output and keeps the stored item hidden until the consumer moves on.

The consumer never waits. On each read request it first looks at the cell after its own. If the producer is not there, the consumer moves into that cell and returns its contents. Otherwise it stays where it is and returns the item it already holds, with a re-read flag raised. Cell 0 holds a preset item from reset, so a read always has something to return.

Both sides share one clock, but their request strobes are independent. When both requests arrive in the same cycle, each side decides from the other side's flags as they were registered before that cycle.

Top module: `rrb_buffer`

## Requirements
- R1: After reset the producer owns cell 1, the consumer owns cell 0, and cell 0 holds the parameter value INIT_WORD. `wr_ready` is 1 and `rd_valid` is 0. The first read with no committed write returns INIT_WORD with `rd_reread` = 0.
- R2: Each side's position is a one-hot set of N bits. Only the owning side updates it. Because of this, exactly N-2 items can be committed past an unread head before the producer must wait.
- R3: A write accepted while `wr_ready` = 1 stores `wr_data` into the producer's cell. In the same cycle the producer advances to the next cell (index + 1 mod N) when the consumer did not own that cell before the edge. The item then becomes readable.
- R4: If an accepted write cannot advance, `wr_ready` is 0 from the next cycle on. Write requests are ignored while `wr_ready` is 0. The producer advances, and `wr_ready` returns to 1, in the first cycle in which the consumer no longer owns the target cell.
- R5: Every read request yields `rd_valid` = 1 one cycle later, whatever the producer is doing. The consumer advances when the producer does not own the next cell. Otherwise it keeps its cell.
- R6: `rd_reread` is 1, together with `rd_valid`, exactly when the consumer kept its cell and the returned item was already returned by an earlier read.
- R7: The two positions never name the same cell, and the producer never stores into the cell the consumer is reading.
- R8: Items are returned in the order they were committed, and none is skipped. An item is repeated only when no newer committed item exists at the moment of the read decision.
- R9: When write and read requests fall in the same cycle, both decisions use the other side's flags from before the edge, and R7 and R8 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer write strobe |
| wr_data | input | W | Item to store |
| wr_ready | output | 1 | 1 when a write strobe will be accepted |
| rd_req | input | 1 | Consumer read strobe |
| rd_data | output | W | Returned item, valid with rd_valid |
| rd_valid | output | 1 | One cycle after each read strobe |
| rd_reread | output | 1 | Returned item repeats the previous delivery |

## Verification
The embedded assertions check the structural properties on every cycle:
- both positions stay one-hot;
- the positions never overlap, and a store never lands on the cell being read;
- each position only ever holds or steps by one;
- a read strobe always produces a valid strobe;
- ignored writes never store;
- a re-read never moves the consumer.

Delivery order, the absence of skipped items, the exact stall depth of N-2 and the same-cycle decision rule can only be shown by the bench's scenarios. The bench compares every returned item and flag against an abstract queue, both in directed fill-and-drain sequences and in long random interleavings.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int MIN_CELLS = 3;
  typedef enum logic [1:0] {RD_IDLE, RD_ADVANCE, RD_REPEAT} rd_choice_e;
endpackage

// File: rtl/rrb_producer_flags.sv
module rrb_producer_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [N-1:0] cons_oh,
  output logic [N-1:0] prod_oh,
  output logic         wr_ready,
  output logic         store_en,
  output logic         prod_adv
);
  function automatic logic [N-1:0] step_fwd(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  localparam logic [N-1:0] PROD_START = {{(N-2){1'b0}}, 2'b10};

  logic [N-1:0] prod_q;
  logic         hold_q;
  logic         accept, want, blocked;

  assign accept   = wr_req & ~hold_q;
  assign want     = accept | hold_q;
  assign blocked  = |(step_fwd(prod_q) & cons_oh);
  assign prod_adv = want & ~blocked;
  assign store_en = accept;
  assign wr_ready = ~hold_q;
  assign prod_oh  = prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= PROD_START;
      hold_q <= 1'b0;
    end else begin
      if (prod_adv) prod_q <= step_fwd(prod_q);
      hold_q <= want & ~prod_adv;
    end
  end

  // R2
  prod_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(prod_q));
  // R3
  prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_adv |=> prod_q == step_fwd($past(prod_q)));
  // R4
  stall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !store_en);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && blocked) |=> $stable(prod_q) && !wr_ready);
endmodule

// File: rtl/rrb_consumer_flags.sv
module rrb_consumer_flags
  import rrb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_req,
  input  logic [N-1:0] prod_oh,
  output logic [N-1:0] cons_oh,
  output logic [N-1:0] rd_sel_oh,
  output logic         rd_valid,
  output logic         rd_reread
);
  function automatic logic [N-1:0] step_fwd(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  localparam logic [N-1:0] CONS_START = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] cons_q;
  logic         seen_q, valid_q, reread_q;
  logic         clear;
  rd_choice_e   choice;

  assign clear = ~|(step_fwd(cons_q) & prod_oh);

  always_comb begin
    if (!rd_req)    choice = RD_IDLE;
    else if (clear) choice = RD_ADVANCE;
    else            choice = RD_REPEAT;
  end

  assign rd_sel_oh = (choice == RD_ADVANCE) ? step_fwd(cons_q) : cons_q;
  assign cons_oh   = cons_q;
  assign rd_valid  = valid_q;
  assign rd_reread = reread_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_q   <= CONS_START;
      seen_q   <= 1'b0;
      valid_q  <= 1'b0;
      reread_q <= 1'b0;
    end else begin
      valid_q  <= rd_req;
      reread_q <= (choice == RD_REPEAT) & seen_q;
      if (rd_req) seen_q <= 1'b1;
      if (choice == RD_ADVANCE) cons_q <= step_fwd(cons_q);
    end
  end

  // R2
  cons_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(cons_q));
  // R5
  never_block_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> rd_valid);
  // R5
  cons_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (cons_q == $past(cons_q)) || (cons_q == step_fwd($past(cons_q))));
  // R6
  reread_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reread |-> rd_valid && $stable(cons_q));
endmodule

// File: rtl/rrb_cell_store.sv
module rrb_cell_store #(
  parameter int N = 4,
  parameter int W = 8,
  parameter logic [W-1:0] INIT_WORD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         store_en,
  input  logic [N-1:0] wr_sel_oh,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [N-1:0] rd_sel_oh,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] cells [N];
  logic [W-1:0] pick;
  logic [W-1:0] out_q;

  for (genvar k = 0; k < N; k++) begin : g_cell
    localparam logic [W-1:0] RST_VAL = (k == 0) ? INIT_WORD : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cells[k] <= RST_VAL;
      else if (store_en && wr_sel_oh[k]) cells[k] <= wr_data;
    end
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_sel_oh[k]) pick = pick | cells[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (rd_en) out_q <= pick;
  end

  assign rd_data = out_q;
endmodule

// File: rtl/rrb_buffer.sv
module rrb_buffer #(
  parameter int N = 4,
  parameter int W = 8,
  parameter logic [W-1:0] INIT_WORD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         rd_reread
);
  logic [N-1:0] prod_oh, cons_oh, rd_sel_oh;
  logic         store_en, prod_adv;

  rrb_producer_flags #(.N(N)) u_prod (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .cons_oh(cons_oh),
    .prod_oh(prod_oh), .wr_ready(wr_ready), .store_en(store_en), .prod_adv(prod_adv)
  );

  rrb_consumer_flags #(.N(N)) u_cons (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .prod_oh(prod_oh),
    .cons_oh(cons_oh), .rd_sel_oh(rd_sel_oh), .rd_valid(rd_valid), .rd_reread(rd_reread)
  );

  rrb_cell_store #(.N(N), .W(W), .INIT_WORD(INIT_WORD)) u_store (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .wr_sel_oh(prod_oh),
    .wr_data(wr_data), .rd_en(rd_req), .rd_sel_oh(rd_sel_oh), .rd_data(rd_data)
  );

  // R7
  cells_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_oh & cons_oh) == '0);
  // R7 R9
  store_read_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && rd_req) |-> (prod_oh & rd_sel_oh) == '0);
  // R9
  both_move_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_adv && rd_req) |=> (prod_oh & cons_oh) == '0);
endmodule

// File: tb/rrb_buffer_bench.sv
`timescale 1ns/1ps
module rrb_buffer_bench;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [W-1:0] INIT = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, rd_valid, rd_reread;
  logic [W-1:0] rd_data;

  always #2 clk = ~clk;

  rrb_buffer #(.N(N), .W(W), .INIT_WORD(INIT)) u_rrb_buffer (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .rd_reread(rd_reread)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // abstract queue model: head is the item the consumer holds
  logic [W-1:0] q[$];
  logic [W-1:0] pend;
  bit m_hold = 0, m_seen = 0;
  bit exp_ready = 1, exp_valid = 0, exp_reread = 0;
  logic [W-1:0] exp_data = '0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model one clock edge, apply stimulus, compare one cycle later
  task automatic step(input string phase, input bit wr, input logic [W-1:0] d, input bit rd);
    int sz = q.size();
    bit both = wr && rd;
    exp_valid  = rd;
    exp_reread = 0;
    if (rd) begin
      if (sz > 1) void'(q.pop_front());
      else exp_reread = m_seen;
      exp_data = q[0];
      m_seen = 1;
    end
    if (!m_hold && wr) begin
      if (sz < N - 1) q.push_back(d);
      else begin pend = d; m_hold = 1; end
    end else if (m_hold && sz < N - 1) begin
      q.push_back(pend);
      m_hold = 0;
    end
    exp_ready = !m_hold;
    wr_req = wr; wr_data = d; rd_req = rd;
    @(posedge clk);
    @(negedge clk);
    wr_req = 0; rd_req = 0;
    check({phase, " R4 ready"}, W'(wr_ready), W'(exp_ready));
    check({phase, " R5 valid"}, W'(rd_valid), W'(exp_valid));
    if (exp_valid) begin
      check({phase, both ? " R9 data" : (exp_reread ? " R7 R8 data" : " R3 R8 data")},
            rd_data, exp_data);
      check({phase, " R6 reread"}, W'(rd_reread), W'(exp_reread));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    q.push_back(INIT);
    repeat (3) @(negedge clk);
    check("R1 reset ready", W'(wr_ready), W'(1));
    check("R1 reset valid", W'(rd_valid), W'(0));
    rst_n = 1;
    @(negedge clk);
    // R1: first read returns preset item, not a repeat; R6: second read repeats it
    step("R1", 0, '0, 1);
    step("R6", 0, '0, 1);
    // R2 R4: N-2 commits, then a stall; write while stalled ignored
    step("R2", 1, 8'h11, 0);
    step("R2", 1, 8'h22, 0);
    step("R2 R4", 1, 8'h33, 0);
    step("R4 ignored", 1, 8'h44, 0);
    step("R4", 0, '0, 0);
    step("R4 drain", 0, '0, 1);
    step("R4 drain", 0, '0, 1);
    step("R4 drain", 0, '0, 1);
    step("R6 empty", 0, '0, 1);
    // R9: same-cycle requests
    for (int i = 0; i < 12; i++) step("R9", 1, W'(8'h50 + i), 1);
    // R8: random interleaving
    for (int i = 0; i < 4000; i++) begin
      int pw = (i / 500) % 2 == 0 ? 70 : 30;
      step("R8", ($urandom % 100) < pw, W'($urandom), ($urandom % 100) < 50);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule